// File: doc/BRIEF.md
# Operand Space Decoder for a Register-less Memory-to-Memory Processor

This block resolves the 6-bit operand addresses of an 8-bit processor that has no register file: every instruction reads two operands from, and writes one result to, a single flat operand space. The decoder turns each access into the right action. That action is a data RAM access, a hard-wired small constant, a configurable constant, a 5-bit stack pointer, an indirect RAM access through one of those pointers, or a control side effect. The side effects are a jump request carrying a label, and a load of the clock-control register with its halt bit.

The sequencer presents one access per cycle with `acc_en`, `acc_we`, `acc_addr` and `acc_wdata`. Read data and its valid flag appear one cycle after the strobe, because the RAM is read synchronously. Jump and clock-control writes come out as single-cycle pulses in that same cycle. The data RAM is a plain behavioural array of the style that maps onto block RAM. Its contents are not reset.

Top module: `opspace_decoder`

## Requirements
- R1: Addresses 0 to 31 access the data RAM word whose index is the low five address bits; a read presents the stored word on `rd_data` in the cycle after the strobe.
- R2: Reads of addresses 32 to 47 return the address minus 32, that is the values 0 to 15.
- R3: Reads of addresses 48 to 59 return configurable constant n = address minus 48, taken from bits [8n+7:8n] of `cfg_consts`.
- R4: Address 60 holds pointer P0 and address 62 holds pointer P1; a write stores only the low five data bits, and a read returns that value with bits 7:5 zero.
- R5: An access to address 61 reads or writes the RAM word whose index is the current P0, and address 63 does the same through P1.
- R6: A write to address 32 raises `jump_req` for exactly the next cycle, with `jump_label` equal to the written data, and changes no stored state.
- R7: A write to address 33 loads `clk_ctrl` with the data, raises `clk_wr` for exactly the next cycle, and `halt` then equals bit 7 of the stored value.
- R8: Writes to addresses 34 to 59 change no RAM word, pointer or `clk_ctrl` value, raise no pulse, and leave the constants unchanged on read.
- R9: While reset is high and after it, all outputs are zero, both pointers read back as zero, and `halt` is low.
- R10: `rd_valid` is high for exactly the one cycle after each read strobe and is low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 6 | Operand address |
| acc_wdata | input | 8 | Write data |
| cfg_consts | input | 96 | Twelve 8-bit configurable constants, entry n at bits [8n+7:8n] |
| rd_data | output | 8 | Read result, valid with `rd_valid` |
| rd_valid | output | 1 | Pulse one cycle after a read strobe |
| jump_req | output | 1 | One-cycle jump request pulse |
| jump_label | output | 8 | Label of the last jump request |
| clk_wr | output | 1 | One-cycle pulse after a clock-control write |
| clk_ctrl | output | 8 | Clock-control register |
| halt | output | 1 | Halt command, bit 7 of `clk_ctrl` |

## Verification
The bench builds the block with its default sizes: an 8-bit data path, a 6-bit address, 32 RAM words, 5-bit pointers and twelve configurable constants. At these sizes the whole 64-location space can be swept outright. Every RAM word, small constant and configurable constant is read. Each pointer gets all 256 write values, which shows the truncation and zero extension. All 32 pointer positions are taken through both indirect locations. Every ignored address in 34 to 59 is written and the full space is then read back unchanged.

// File: rtl/opspace_pkg.sv
package opspace_pkg;

  typedef enum logic [2:0] {
    RGN_RAM   = 3'd0,
    RGN_SMALL = 3'd1,
    RGN_CFG   = 3'd2,
    RGN_PTR   = 3'd3,
    RGN_PIND  = 3'd4
  } rgn_e;

endpackage

// File: rtl/opspace_addr_map.sv
module opspace_addr_map
  import opspace_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int RAM_AW    = 5,
  parameter int SMALL_CNT = 16,
  parameter int CFG_CNT   = 12,
  parameter int PTR_W     = 5,
  localparam int CFG_IW   = $clog2(CFG_CNT)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PTR_W-1:0]  ptr0,
  input  logic [PTR_W-1:0]  ptr1,
  output rgn_e              rgn,
  output logic [RAM_AW-1:0] ram_idx,
  output logic              ptr_sel,
  output logic [DATA_W-1:0] small_val,
  output logic [CFG_IW-1:0] cfg_idx
);

  localparam int SMALL_BASE = 2 ** RAM_AW;
  localparam int CFG_BASE   = SMALL_BASE + SMALL_CNT;
  localparam int PTR_BASE   = CFG_BASE + CFG_CNT;

  // Pointer block is four words aligned on four: bit 1 picks the pointer,
  // bit 0 picks direct (pointer value) or indirect (RAM through pointer).
  always_comb begin
    rgn       = RGN_RAM;
    ram_idx   = addr[RAM_AW-1:0];
    ptr_sel   = addr[1];
    small_val = DATA_W'(addr - ADDR_W'(SMALL_BASE));
    cfg_idx   = CFG_IW'(addr - ADDR_W'(CFG_BASE));
    if (addr < ADDR_W'(SMALL_BASE)) begin
      rgn = RGN_RAM;
    end else if (addr < ADDR_W'(CFG_BASE)) begin
      rgn = RGN_SMALL;
    end else if (addr < ADDR_W'(PTR_BASE)) begin
      rgn = RGN_CFG;
    end else if (addr[0]) begin
      rgn     = RGN_PIND;
      ram_idx = RAM_AW'(addr[1] ? ptr1 : ptr0);
    end else begin
      rgn = RGN_PTR;
    end
  end

endmodule

// File: rtl/opspace_ram.sv
module opspace_ram #(
  parameter int DATA_W = 8,
  parameter int RAM_AW = 5,
  localparam int DEPTH = 2 ** RAM_AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [RAM_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Single port, synchronous read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/opspace_ctl_regs.sv
module opspace_ctl_regs #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr0_we,
  input  logic              ptr1_we,
  input  logic              jump_we,
  input  logic              clkc_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr0,
  output logic [PTR_W-1:0]  ptr1,
  output logic              jump_req,
  output logic [DATA_W-1:0] jump_label,
  output logic              clk_wr,
  output logic [DATA_W-1:0] clk_ctrl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr0       <= '0;
      ptr1       <= '0;
      jump_req   <= 1'b0;
      jump_label <= '0;
      clk_wr     <= 1'b0;
      clk_ctrl   <= '0;
    end else begin
      jump_req <= jump_we;
      clk_wr   <= clkc_we;
      if (ptr0_we) ptr0 <= wdata[PTR_W-1:0];
      if (ptr1_we) ptr1 <= wdata[PTR_W-1:0];
      if (jump_we) jump_label <= wdata;
      if (clkc_we) clk_ctrl <= wdata;
    end
  end

  a_r6_jump_pulse: assert property (@(posedge clk) disable iff (rst)
    jump_we |=> jump_req && jump_label == $past(wdata));
  a_r6_jump_only_on_write: assert property (@(posedge clk) disable iff (rst)
    jump_req |-> $past(jump_we));
  a_r7_clk_load: assert property (@(posedge clk) disable iff (rst)
    clkc_we |=> clk_wr && clk_ctrl == $past(wdata));
  a_r7_clk_hold: assert property (@(posedge clk) disable iff (rst)
    !clkc_we |=> !clk_wr && $stable(clk_ctrl));

endmodule

// File: rtl/opspace_decoder.sv
module opspace_decoder
  import opspace_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int RAM_AW    = 5,
  parameter int SMALL_CNT = 16,
  parameter int CFG_CNT   = 12,
  parameter int PTR_W     = 5,
  parameter int HALT_BIT  = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      acc_en,
  input  logic                      acc_we,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [DATA_W-1:0]         acc_wdata,
  input  logic [CFG_CNT*DATA_W-1:0] cfg_consts,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      rd_valid,
  output logic                      jump_req,
  output logic [DATA_W-1:0]         jump_label,
  output logic                      clk_wr,
  output logic [DATA_W-1:0]         clk_ctrl,
  output logic                      halt
);

  localparam int CFG_IW     = $clog2(CFG_CNT);
  localparam int SMALL_BASE = 2 ** RAM_AW;
  localparam int CFG_BASE   = SMALL_BASE + SMALL_CNT;
  localparam int JUMP_ADDR  = SMALL_BASE;
  localparam int CLKC_ADDR  = SMALL_BASE + 1;

  rgn_e              rgn;
  logic [RAM_AW-1:0] ram_idx;
  logic              ptr_sel;
  logic [DATA_W-1:0] small_val;
  logic [CFG_IW-1:0] cfg_idx;
  logic [PTR_W-1:0]  ptr0, ptr1;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] other_val;
  logic [DATA_W-1:0] other_q;
  logic              from_ram_q;

  logic do_rd, do_wr, hits_ram;
  assign do_rd    = acc_en && !acc_we;
  assign do_wr    = acc_en && acc_we;
  assign hits_ram = (rgn == RGN_RAM) || (rgn == RGN_PIND);

  opspace_addr_map #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_AW(RAM_AW),
    .SMALL_CNT(SMALL_CNT), .CFG_CNT(CFG_CNT), .PTR_W(PTR_W)
  ) map_i (
    .addr(acc_addr), .ptr0(ptr0), .ptr1(ptr1), .rgn(rgn),
    .ram_idx(ram_idx), .ptr_sel(ptr_sel), .small_val(small_val),
    .cfg_idx(cfg_idx)
  );

  opspace_ram #(.DATA_W(DATA_W), .RAM_AW(RAM_AW)) ram_i (
    .clk(clk), .we(do_wr && hits_ram), .re(do_rd && hits_ram),
    .addr(ram_idx), .wdata(acc_wdata), .rdata(ram_q)
  );

  opspace_ctl_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) ctl_i (
    .clk(clk), .rst(rst),
    .ptr0_we(do_wr && rgn == RGN_PTR && !ptr_sel),
    .ptr1_we(do_wr && rgn == RGN_PTR && ptr_sel),
    .jump_we(do_wr && acc_addr == ADDR_W'(JUMP_ADDR)),
    .clkc_we(do_wr && acc_addr == ADDR_W'(CLKC_ADDR)),
    .wdata(acc_wdata), .ptr0(ptr0), .ptr1(ptr1),
    .jump_req(jump_req), .jump_label(jump_label),
    .clk_wr(clk_wr), .clk_ctrl(clk_ctrl)
  );

  // Non-RAM read value, chosen by region.
  always_comb begin
    unique case (rgn)
      RGN_SMALL: other_val = small_val;
      RGN_CFG:   other_val = cfg_consts[int'(cfg_idx)*DATA_W +: DATA_W];
      RGN_PTR:   other_val = DATA_W'(ptr_sel ? ptr1 : ptr0);
      default:   other_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      from_ram_q <= 1'b0;
      other_q    <= '0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) begin
        from_ram_q <= hits_ram;
        other_q    <= hits_ram ? '0 : other_val;
      end
    end
  end

  assign rd_data = from_ram_q ? ram_q : other_q;
  assign halt    = clk_ctrl[HALT_BIT];

  // R10: read valid follows the read strobe by one cycle
  a_r10_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    do_rd |=> rd_valid);
  a_r10_no_valid_otherwise: assert property (@(posedge clk) disable iff (rst)
    !do_rd |=> !rd_valid);
  // R4: pointer reads come back zero-extended
  a_r4_ptr_zext: assert property (@(posedge clk) disable iff (rst)
    (do_rd && rgn == RGN_PTR) |=> (rd_data >> PTR_W) == '0);
  // R2: small constants read back as their offset
  a_r2_small_const: assert property (@(posedge clk) disable iff (rst)
    (do_rd && rgn == RGN_SMALL) |=>
      rd_data == DATA_W'($past(acc_addr) - ADDR_W'(SMALL_BASE)));
  // R8: writes into the constant range past the control words do nothing
  a_r8_ignored_write: assert property (@(posedge clk) disable iff (rst)
    (do_wr && acc_addr > ADDR_W'(CLKC_ADDR) && rgn != RGN_PTR && rgn != RGN_PIND
      && acc_addr >= ADDR_W'(SMALL_BASE)) |=> !jump_req && !clk_wr && $stable(clk_ctrl));
  // R6/R7/R10: at most one result pulse per cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_valid, jump_req, clk_wr}));
  // R3: configurable constant region is addressed inside the vector
  a_r3_cfg_range: assert property (@(posedge clk) disable iff (rst)
    (rgn == RGN_CFG) |-> int'(cfg_idx) < CFG_CNT && acc_addr >= ADDR_W'(CFG_BASE));

endmodule

// File: tb/opspace_decoder_tb.sv
module opspace_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCFG = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         acc_en = 1'b0;
  logic         acc_we = 1'b0;
  logic [5:0]   acc_addr = '0;
  logic [7:0]   acc_wdata = '0;
  logic [95:0]  cfg_consts;
  logic [7:0]   rd_data, jump_label, clk_ctrl;
  logic         rd_valid, jump_req, clk_wr, halt;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [7:0] ram_m [32];
  logic [4:0] p0_m, p1_m;
  logic [7:0] clk_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  opspace_decoder dut_i (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .cfg_consts(cfg_consts),
    .rd_data(rd_data), .rd_valid(rd_valid), .jump_req(jump_req),
    .jump_label(jump_label), .clk_wr(clk_wr), .clk_ctrl(clk_ctrl), .halt(halt)
  );

  function automatic logic [7:0] cfg_val(int n);
    return 8'((n * 29 + 3) & 255);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at falling edge, sampled by the rising edge, results checked at the next falling edge.
  task automatic do_wr(logic [5:0] a, logic [7:0] d);
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    @(posedge clk); @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic do_rd(logic [5:0] a, output logic [7:0] d, output logic v);
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data; v = rd_valid;
    acc_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [7:0] exp);
    logic [7:0] d; logic v;
    do_rd(a, d, v);
    chk(req, d, exp);
    chk("R10", {7'd0, v}, 8'd1);
  endtask

  task automatic full_readback(string req);
    for (int i = 0; i < 32; i++) rd_chk(req, 6'(i), ram_m[i]);
    for (int i = 0; i < 16; i++) rd_chk(req, 6'(32 + i), 8'(i));
    for (int i = 0; i < NCFG; i++) rd_chk(req, 6'(48 + i), cfg_val(i));
    rd_chk(req, 6'd60, {3'b0, p0_m});
    rd_chk(req, 6'd62, {3'b0, p1_m});
    rd_chk(req, 6'd61, ram_m[p0_m]);
    rd_chk(req, 6'd63, ram_m[p1_m]);
  endtask

  initial begin
    for (int i = 0; i < NCFG; i++) cfg_consts[i*8 +: 8] = cfg_val(i);
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: outputs during reset
    chk("R9", rd_data, 8'd0);
    chk("R9", {4'd0, rd_valid, jump_req, clk_wr, halt}, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", clk_ctrl, 8'd0);
    chk("R9", jump_label, 8'd0);
    rd_chk("R9", 6'd60, 8'd0);
    rd_chk("R9", 6'd62, 8'd0);
    p0_m = '0; p1_m = '0; clk_m = '0;

    // R1: fill and read back every RAM word
    for (int i = 0; i < 32; i++) begin
      ram_m[i] = 8'((i * 37 + 11) & 255);
      do_wr(6'(i), ram_m[i]);
      chk("R10", {7'd0, rd_valid}, 8'd0);
    end
    for (int i = 0; i < 32; i++) rd_chk("R1", 6'(i), ram_m[i]);

    // R2, R3: constant regions
    for (int i = 0; i < 16; i++) rd_chk("R2", 6'(32 + i), 8'(i));
    for (int i = 0; i < NCFG; i++) rd_chk("R3", 6'(48 + i), cfg_val(i));

    // R4: every write value through both pointers
    for (int w = 0; w < 256; w++) begin
      do_wr(6'd60, 8'(w));
      rd_chk("R4", 6'd60, 8'(w & 31));
      do_wr(6'd62, 8'(255 - w));
      rd_chk("R4", 6'd62, 8'((255 - w) & 31));
    end
    p0_m = 5'(0); p1_m = 5'(0);

    // R5: indirect writes through P0, indirect reads through P1
    for (int p = 0; p < 32; p++) begin
      do_wr(6'd60, 8'(p | 8'hE0));
      ram_m[p] = 8'((p * 91 + 5) & 255);
      do_wr(6'd61, ram_m[p]);
      rd_chk("R5", 6'(p), ram_m[p]);
      do_wr(6'd62, 8'(31 - p));
      rd_chk("R5", 6'd63, ram_m[31 - p]);
      rd_chk("R5", 6'd61, ram_m[p]);
    end
    p0_m = 5'd31; p1_m = 5'd0;
    do_wr(6'd63, 8'h3C); ram_m[0] = 8'h3C;
    rd_chk("R5", 6'd0, 8'h3C);

    // R6: jump requests
    foreach (ram_m[k]) if (k < 4) begin
      logic [7:0] lab;
      lab = 8'((k * 83 + 17) & 255);
      do_wr(6'd32, lab);
      chk("R6", {6'd0, jump_req, clk_wr}, 8'd2);
      chk("R6", jump_label, lab);
      @(negedge clk);
      chk("R6", {7'd0, jump_req}, 8'd0);
    end

    // R7: clock-control writes and halt bit
    for (int k = 0; k < 4; k++) begin
      logic [7:0] cv;
      cv = (k == 0) ? 8'h80 : (k == 1) ? 8'h7F : (k == 2) ? 8'hFF : 8'h00;
      do_wr(6'd33, cv);
      clk_m = cv;
      chk("R7", {6'd0, clk_wr, jump_req}, 8'd2);
      chk("R7", clk_ctrl, cv);
      chk("R7", {7'd0, halt}, {7'd0, cv[7]});
      @(negedge clk);
      chk("R7", {7'd0, clk_wr}, 8'd0);
      chk("R7", clk_ctrl, cv);
    end
    do_wr(6'd33, 8'hA5); clk_m = 8'hA5;
    chk("R7", {7'd0, halt}, 8'd1);

    // R2: control words read back as constants
    rd_chk("R2", 6'd32, 8'd0);
    rd_chk("R2", 6'd33, 8'd1);

    // R8: writes into ignored locations
    for (int a = 34; a < 60; a++) begin
      do_wr(6'(a), 8'h5A ^ 8'(a));
      chk("R8", {5'd0, jump_req, clk_wr, rd_valid}, 8'd0);
      chk("R8", clk_ctrl, clk_m);
    end
    full_readback("R8");

    // R10: idle cycle gives no valid
    do_rd(6'd5, d, v);
    @(negedge clk);
    chk("R10", {7'd0, rd_valid}, 8'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule